// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the data address for one operand of a processor with sixteen 16-bit working registers. It takes a 3-bit addressing-mode code, the number and current value of the pointer register, the value of an offset register, and the operand size. From these it produces the address to send to memory at once. When the mode changes the pointer, it also produces the new pointer value. That value goes back to the register file one clock later, together with a write enable and the register number.

The increment/decrement modes come in two flavours. Post-modify modes send out the old pointer and write back the changed one. Pre-modify modes change the pointer first, then use the changed value both as the address and as the write-back value. The step follows the operand size: 1 for a byte, 2 for a word and 4 for a long.

A build parameter selects the variant. With the full mode field, code 110 names the status register as the operand. With the reduced field, code 110 is a second encoding of the base-plus-offset mode.

Top module: `opnd_ea_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `o_wb_en`, `o_wb_val` and `o_wb_reg` are all zero.
- R2: Mode 000 (register direct) drives `o_direct`=1, `o_sr_sel`=0 and `o_ea`=0, and the following cycle has `o_wb_en`=0.
- R3: Mode 001 (plain indirect) drives `o_ea` = pointer value and `o_direct`=0, and the following cycle has `o_wb_en`=0.
- R4: Mode 010 (post-decrement) and mode 011 (post-increment) drive `o_ea` = the unmodified pointer combinationally. On the next cycle they give `o_wb_en`=1, `o_wb_reg` = the pointer register number and `o_wb_val` = pointer minus or plus the step.
- R5: Mode 100 (pre-decrement) and mode 101 (pre-increment) drive `o_ea` = pointer minus or plus the step. On the next cycle they give `o_wb_en`=1 and `o_wb_val` equal to that same address.
- R6: With `HAS_SR_MODE`=1, mode 110 drives `o_direct`=1, `o_sr_sel`=1 and `o_ea`=0, and the following cycle has `o_wb_en`=0.
- R7: Mode 111 drives `o_ea` = pointer + offset and `o_direct`=0, and the following cycle has `o_wb_en`=0.
- R8: With `HAS_SR_MODE`=0, mode 110 behaves exactly like mode 111, and `o_sr_sel` is never set.
- R9: The step is 1 when `i_byte`=1 and `i_long`=0, 2 when both are 0, and 4 whenever `i_long`=1 (long overrides byte).
- R10: All address arithmetic wraps modulo 2^16. For example, 0xFFFF + 1 gives 0x0000 and 0x0000 − 4 gives 0xFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_mode | input | 3 | Addressing-mode code |
| i_ptr_reg | input | 4 | Pointer register number |
| i_ptr_val | input | 16 | Current pointer register value |
| i_ofs_val | input | 16 | Offset register value for base-plus-offset mode |
| i_byte | input | 1 | Byte-size operand |
| i_long | input | 1 | Long-size operand (overrides byte) |
| o_ea | output | 16 | Effective address, combinational |
| o_direct | output | 1 | Operand is a register or the status register, not memory |
| o_sr_sel | output | 1 | Operand is the status register |
| o_wb_en | output | 1 | Registered pointer write enable |
| o_wb_reg | output | 4 | Registered pointer register number |
| o_wb_val | output | 16 | Registered new pointer value |

## Verification
Every mode is swept at byte, word and long size, and with byte and long both set. The pointer values used are 0x0000, 0xFFFF and a mid-range value. Comparing the address with the write-back value separates pre-modify from post-modify. The step size shows whether the size decode is right, and the edge pointers expose any missing wrap. Both variants are driven with the same inputs, so code 110 shows the status-register decode in one and the offset alias in the other. Seeded random vectors then cover mixed mode, register and offset combinations.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'b000,
        AM_IND     = 3'b001,
        AM_POSTDEC = 3'b010,
        AM_POSTINC = 3'b011,
        AM_PREDEC  = 3'b100,
        AM_PREINC  = 3'b101,
        AM_SPECIAL = 3'b110,
        AM_OFFSET  = 3'b111
    } am_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } opsz_t;

    typedef struct packed {
        logic direct;   // register operand
        logic sr;       // status register operand
        logic offset;   // base plus offset register
        logic modify;   // pointer is updated
        logic pre;      // update before use
        logic down;     // decrement rather than increment
    } am_dec_t;

    function automatic opsz_t size_of(logic byte_sel, logic long_sel);
        if (long_sel)      return SZ_LONG;
        else if (byte_sel) return SZ_BYTE;
        else               return SZ_WORD;
    endfunction

    function automatic logic [2:0] step_of(opsz_t sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_LONG: return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/opnd_ea_decode.sv
module opnd_ea_decode
    import opnd_ea_pkg::*;
#(
    parameter bit HAS_SR_MODE = 1'b1
) (
    input  logic [2:0] i_mode,
    output am_dec_t    o_dec
);

    am_dec_t special_dec;

    generate
        if (HAS_SR_MODE) begin : g_sr
            always_comb begin
                special_dec        = '0;
                special_dec.sr     = 1'b1;
            end
        end else begin : g_alias
            always_comb begin
                special_dec        = '0;
                special_dec.offset = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        o_dec = '0;
        case (i_mode)
            AM_DIRECT:  o_dec.direct = 1'b1;
            AM_IND:     o_dec        = '0;
            AM_POSTDEC: begin o_dec.modify = 1'b1; o_dec.down = 1'b1; end
            AM_POSTINC: o_dec.modify = 1'b1;
            AM_PREDEC:  begin o_dec.modify = 1'b1; o_dec.pre = 1'b1; o_dec.down = 1'b1; end
            AM_PREINC:  begin o_dec.modify = 1'b1; o_dec.pre = 1'b1; end
            AM_SPECIAL: o_dec        = special_dec;
            default:    o_dec.offset = 1'b1;
        endcase
    end

endmodule

// File: rtl/opnd_ea_arith.sv
module opnd_ea_arith
    import opnd_ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  am_dec_t       i_dec,
    input  opsz_t         i_size,
    input  logic [AW-1:0] i_ptr,
    input  logic [AW-1:0] i_ofs,
    output logic [AW-1:0] o_ea,
    output logic [AW-1:0] o_next
);

    logic [AW-1:0] step;

    assign step   = AW'(step_of(i_size));
    assign o_next = i_dec.down ? (i_ptr - step) : (i_ptr + step);

    always_comb begin
        if (i_dec.direct || i_dec.sr) o_ea = '0;
        else if (i_dec.offset)        o_ea = i_ptr + i_ofs;
        else if (i_dec.pre)           o_ea = o_next;
        else                          o_ea = i_ptr;
    end

endmodule

// File: rtl/opnd_ea_wbreg.sv
module opnd_ea_wbreg #(
    parameter int AW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          i_en,
    input  logic [RW-1:0] i_reg,
    input  logic [AW-1:0] i_val,
    output logic          o_en,
    output logic [RW-1:0] o_reg,
    output logic [AW-1:0] o_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            o_en  <= 1'b0;
            o_reg <= '0;
            o_val <= '0;
        end else begin
            o_en  <= i_en;
            o_reg <= i_en ? i_reg : '0;
            o_val <= i_en ? i_val : '0;
        end
    end

endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
    import opnd_ea_pkg::*;
#(
    parameter int AW          = 16,
    parameter int REG_CNT     = 16,
    parameter bit HAS_SR_MODE = 1'b1,
    localparam int RW         = $clog2(REG_CNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    i_mode,
    input  logic [RW-1:0] i_ptr_reg,
    input  logic [AW-1:0] i_ptr_val,
    input  logic [AW-1:0] i_ofs_val,
    input  logic          i_byte,
    input  logic          i_long,
    output logic [AW-1:0] o_ea,
    output logic          o_direct,
    output logic          o_sr_sel,
    output logic          o_wb_en,
    output logic [RW-1:0] o_wb_reg,
    output logic [AW-1:0] o_wb_val
);

    am_dec_t       dec;
    opsz_t         size;
    logic [AW-1:0] next_ptr;

    assign size = size_of(i_byte, i_long);

    opnd_ea_decode #(.HAS_SR_MODE(HAS_SR_MODE)) u_dec (
        .i_mode (i_mode),
        .o_dec  (dec)
    );

    opnd_ea_arith #(.AW(AW)) u_arith (
        .i_dec  (dec),
        .i_size (size),
        .i_ptr  (i_ptr_val),
        .i_ofs  (i_ofs_val),
        .o_ea   (o_ea),
        .o_next (next_ptr)
    );

    opnd_ea_wbreg #(.AW(AW), .RW(RW)) u_wb (
        .clk   (clk),
        .rst   (rst),
        .i_en  (dec.modify),
        .i_reg (i_ptr_reg),
        .i_val (next_ptr),
        .o_en  (o_wb_en),
        .o_reg (o_wb_reg),
        .o_val (o_wb_val)
    );

    assign o_direct = dec.direct | dec.sr;
    assign o_sr_sel = dec.sr;

endmodule

// File: rtl/opnd_ea_chk.sv
module opnd_ea_chk #(
    parameter int AW          = 16,
    parameter int RW          = 4,
    parameter bit HAS_SR_MODE = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    i_mode,
    input logic [RW-1:0] i_ptr_reg,
    input logic [AW-1:0] i_ptr_val,
    input logic [AW-1:0] i_ofs_val,
    input logic          i_byte,
    input logic          i_long,
    input logic [AW-1:0] o_ea,
    input logic          o_direct,
    input logic          o_sr_sel,
    input logic          o_wb_en,
    input logic [RW-1:0] o_wb_reg,
    input logic [AW-1:0] o_wb_val
);

    logic [AW-1:0] stp;
    logic          mod_mode;
    logic          pre_mode;
    logic [AW-1:0] sum;

    assign stp      = i_long ? AW'(4) : (i_byte ? AW'(1) : AW'(2));
    assign mod_mode = (i_mode >= 3'd2) && (i_mode <= 3'd5);
    assign pre_mode = (i_mode == 3'd4) || (i_mode == 3'd5);
    assign sum      = i_ptr_val + i_ofs_val;

    p_direct_r2: assert property (@(posedge clk) disable iff (rst)
        i_mode == 3'd0 |-> o_direct && !o_sr_sel && o_ea == '0);

    p_plain_r3: assert property (@(posedge clk) disable iff (rst)
        i_mode == 3'd1 |-> !o_direct && o_ea == i_ptr_val);

    p_no_wb_r3: assert property (@(posedge clk) disable iff (rst)
        !mod_mode |=> !o_wb_en);

    p_post_ea_r4: assert property (@(posedge clk) disable iff (rst)
        (i_mode == 3'd2 || i_mode == 3'd3) |-> o_ea == i_ptr_val);

    p_wb_reg_r4: assert property (@(posedge clk) disable iff (rst)
        mod_mode |=> o_wb_en && o_wb_reg == $past(i_ptr_reg));

    p_pre_ea_r5: assert property (@(posedge clk) disable iff (rst)
        i_mode == 3'd4 |-> o_ea == i_ptr_val - stp);

    p_pre_wb_r5: assert property (@(posedge clk) disable iff (rst)
        pre_mode |=> o_wb_val == $past(o_ea));

    p_offset_r7: assert property (@(posedge clk) disable iff (rst)
        i_mode == 3'd7 |-> !o_direct && o_ea == sum);

    generate
        if (HAS_SR_MODE) begin : g_sr_chk
            p_sr_r6: assert property (@(posedge clk) disable iff (rst)
                i_mode == 3'd6 |-> o_direct && o_sr_sel && o_ea == '0);
        end else begin : g_alias_chk
            p_alias_r8: assert property (@(posedge clk) disable iff (rst)
                i_mode == 3'd6 |-> !o_direct && !o_sr_sel && o_ea == sum);
        end
    endgenerate

endmodule

bind opnd_ea_gen opnd_ea_chk #(.AW(AW), .RW(RW), .HAS_SR_MODE(HAS_SR_MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .i_mode    (i_mode),
    .i_ptr_reg (i_ptr_reg),
    .i_ptr_val (i_ptr_val),
    .i_ofs_val (i_ofs_val),
    .i_byte    (i_byte),
    .i_long    (i_long),
    .o_ea      (o_ea),
    .o_direct  (o_direct),
    .o_sr_sel  (o_sr_sel),
    .o_wb_en   (o_wb_en),
    .o_wb_reg  (o_wb_reg),
    .o_wb_val  (o_wb_val)
);

// File: tb/sim_opnd_ea_gen.sv
module sim_opnd_ea_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  i_mode = 3'd3;
    logic [3:0]  i_ptr_reg = 4'd5;
    logic [15:0] i_ptr_val = 16'h1234;
    logic [15:0] i_ofs_val = 16'h0010;
    logic        i_byte = 1'b0;
    logic        i_long = 1'b0;

    logic [15:0] ea0, ea1, wv0, wv1;
    logic        dir0, dir1, sr0, sr1, we0, we1;
    logic [3:0]  wr0, wr1;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    opnd_ea_gen #(.HAS_SR_MODE(1'b1)) u0 (
        .clk(clk), .rst(rst), .i_mode(i_mode), .i_ptr_reg(i_ptr_reg),
        .i_ptr_val(i_ptr_val), .i_ofs_val(i_ofs_val), .i_byte(i_byte), .i_long(i_long),
        .o_ea(ea0), .o_direct(dir0), .o_sr_sel(sr0), .o_wb_en(we0), .o_wb_reg(wr0), .o_wb_val(wv0)
    );

    opnd_ea_gen #(.HAS_SR_MODE(1'b0)) u1 (
        .clk(clk), .rst(rst), .i_mode(i_mode), .i_ptr_reg(i_ptr_reg),
        .i_ptr_val(i_ptr_val), .i_ofs_val(i_ofs_val), .i_byte(i_byte), .i_long(i_long),
        .o_ea(ea1), .o_direct(dir1), .o_sr_sel(sr1), .o_wb_en(we1), .o_wb_reg(wr1), .o_wb_val(wv1)
    );

    function automatic logic [15:0] e_step(bit b, bit l);
        if (l) return 16'd4;
        if (b) return 16'd1;
        return 16'd2;
    endfunction

    function automatic logic [15:0] e_ea(int m, bit srv, logic [15:0] p, logic [15:0] o, bit b, bit l);
        case (m)
            0:       return 16'h0;
            4:       return p - e_step(b, l);
            5:       return p + e_step(b, l);
            6:       return srv ? 16'h0 : p + o;
            7:       return p + o;
            default: return p;
        endcase
    endfunction

    function automatic string e_tag(int m, bit srv);
        case (m)
            0:      return "R2";
            1:      return "R3";
            2, 3:   return "R4/R9/R10";
            4, 5:   return "R5/R9/R10";
            6:      return srv ? "R6" : "R8";
            default: return "R7/R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(int m, logic [3:0] r, logic [15:0] p, logic [15:0] o, bit b, bit l);
        logic [15:0] ex_wb;
        bit          ex_en;
        @(negedge clk);
        i_mode = 3'(m); i_ptr_reg = r; i_ptr_val = p; i_ofs_val = o; i_byte = b; i_long = l;
        #1;
        chk({e_tag(m, 1), " ea"},        32'(ea0),  32'(e_ea(m, 1, p, o, b, l)));
        chk({e_tag(m, 1), " direct"},    32'(dir0), 32'((m == 0) || (m == 6)));
        chk({e_tag(m, 1), " sr"},        32'(sr0),  32'(m == 6));
        chk({e_tag(m, 0), " ea alt"},    32'(ea1),  32'(e_ea(m, 0, p, o, b, l)));
        chk({e_tag(m, 0), " dir alt"},   32'({dir1, sr1}), 32'({(m == 0), 1'b0}));
        ex_en = (m >= 2) && (m <= 5);
        ex_wb = (m == 2 || m == 4) ? p - e_step(b, l) : p + e_step(b, l);
        @(posedge clk);
        #1;
        chk({e_tag(m, 1), " wb_en"},     32'(we0), 32'(ex_en));
        chk({e_tag(m, 0), " wb_en alt"}, 32'(we1), 32'(ex_en));
        if (ex_en) begin
            chk({e_tag(m, 1), " wb_val"}, 32'(wv0), 32'(ex_wb));
            chk({e_tag(m, 1), " wb_reg"}, 32'(wr0), 32'(r));
            chk({e_tag(m, 0), " wb_val alt"}, 32'(wv1), 32'(ex_wb));
        end
    endtask

    initial begin
        int sz_b [4] = '{1, 0, 0, 1};
        int sz_l [4] = '{0, 0, 1, 1};
        logic [15:0] ptrs [3] = '{16'h0000, 16'hFFFF, 16'h8001};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 wb_en in reset", 32'({we0, we1}), 32'(0));
        chk("R1 wb_val in reset", 32'({wv0, wv1}), 32'(0));
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 wb_reg after reset", 32'({wr0, wr1}), 32'(0));
        // directed sweep: every mode, every size, edge pointers (R9, R10)
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 3; k++)
                    apply(m, 4'(m + s), ptrs[k], 16'hFFFE - 16'(k), sz_b[s][0], sz_l[s][0]);
        // R10 wrap examples written out
        apply(5, 4'd2, 16'hFFFF, 16'h0, 1'b1, 1'b0);
        apply(4, 4'd3, 16'h0000, 16'h0, 1'b0, 1'b1);
        // seeded random mix
        for (int i = 0; i < 400; i++)
            apply(int'($urandom % 8), 4'($urandom), 16'($urandom), 16'($urandom),
                  1'($urandom), 1'($urandom));
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule